// File: doc/BRIEF.md
# Receive Character Queue with Per-Entry Error Tags

This block sits between a serial receive deserializer and the register interface of a UART. Every character the deserializer delivers is stored with its own 4-bit error tag in a 16-entry first-in first-out queue. Software reads an entry in two steps: it reads the tag first, then the character. Reading the character removes the entry. A character that arrives while the queue is full is dropped. The loss is flagged on the next tag that software reads.

The block drives a status word with the fill level, a full flag and a sticky queue-error flag. It also keeps two write-one-to-clear interrupt flags. The level flag is set when a stored character brings the fill level up to a selectable trigger. The idle flag is set when the line has been quiet for a set number of character times, and it is set even when the queue is empty.

Top module: `rx_err_fifo`

## Requirements
- R1: The queue holds 16 entries. `fifo_stat[3:0]` is the entry count modulo 16 and `fifo_stat[8]` is the full flag, so a full queue shows count 0 with bit 8 set. A character offered while the queue is full, with no pop in the same cycle, is dropped.
- R2: Entries come out in arrival order. `rd_data` shows the oldest character, and a `data_rd` pulse removes that entry. A `data_rd` pulse on an empty queue changes nothing.
- R3: `rd_tag` shows the tag of the oldest entry. Bit 0 is overrun, bit 1 is parity error, bit 2 is frame error and bit 3 is break. The `char_err` input carries parity on bit 0, frame on bit 1 and break on bit 2.
- R4: After a character is dropped, bit 0 of `rd_tag` reads 1 until the next `tag_rd` pulse on a non-empty queue. That read clears it.
- R5: `fifo_stat[10]` is set while an overrun is pending or any stored entry with a nonzero tag has not had its tag read. It clears once the last such tag is read, or its entry is popped.
- R6: A `trig_sel` value of 0, 1, 2 or 3 selects a level of 4, 8, 12 or 16 entries. `irq_flags[0]` is set when a stored character leaves the count at or above that level.
- R7: With `tout_en` high, `irq_flags[1]` is set once 60 cycles (3 character times of 20 cycles) pass without `char_vld`. This happens even when the queue is empty. Each `char_vld` pulse restarts the count, and `tout_en` low holds the count at zero.
- R8: Writing 1 to a bit of `irq_clr` clears that interrupt flag. An event in the same cycle as the clear leaves the flag set.
- R9: `fifo_clr` empties the queue, zeroes the count, clears the queue-error flag and any pending overrun, and drops a character offered in the same cycle.
- R10: After reset the status word, both interrupt flags, `rd_data` and `rd_tag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_clr | input | 1 | Synchronous queue flush |
| trig_sel | input | 2 | Level trigger select |
| tout_en | input | 1 | Idle timeout enable |
| char_vld | input | 1 | Character strobe from deserializer |
| char_data | input | 8 | Received character |
| char_err | input | 3 | Parity, frame and break flags of the character |
| data_rd | input | 1 | Data register read strobe (pops) |
| tag_rd | input | 1 | Error register read strobe |
| irq_clr | input | 2 | Write-one-to-clear for the interrupt flags |
| rd_data | output | 8 | Oldest character |
| rd_tag | output | 4 | Error tag of the oldest entry |
| fifo_stat | output | 16 | Count, full and queue-error status word |
| irq_flags | output | 2 | Level (bit 0) and idle timeout (bit 1) flags |

## Verification
Directed sequences fill the queue to exactly 16 entries and then offer one more character. This separates a correct drop-and-flag from wrapping, and shows that the overrun lands on the next tag read. Tags are read both before pops and skipped entirely, which tells apart a queue-error flag that tracks unread tags from one that only tracks stored ones. Long quiet stretches with an empty queue test the idle flag on its own, away from any data. A seeded random mix of strobes, flushes, clears and trigger changes is then run against a per-cycle reference model to catch ordering and same-cycle collisions.

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
  parameter int DEPTH      = 16,
  parameter int DATA_W     = 8,
  parameter int CHAR_CYC   = 20,
  parameter int TOUT_CHARS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_clr,
  input  logic [1:0]        trig_sel,
  input  logic              tout_en,
  input  logic              char_vld,
  input  logic [DATA_W-1:0] char_data,
  input  logic [2:0]        char_err,
  input  logic              data_rd,
  input  logic              tag_rd,
  input  logic [1:0]        irq_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic [3:0]        rd_tag,
  output logic [15:0]       fifo_stat,
  output logic [1:0]        irq_flags
);

  localparam int PTR_W    = $clog2(DEPTH);
  localparam int CNT_W    = PTR_W + 1;
  localparam int TOUT_LIM = CHAR_CYC * TOUT_CHARS;
  localparam int TC_W     = $clog2(TOUT_LIM + 1);

  logic [DATA_W-1:0] dmem [DEPTH];
  logic [2:0]        emem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count, cnt_nxt, err_cnt, rx_lvl;
  logic [TC_W-1:0]   tcnt;
  logic              ovr_pend, tag_seen;

  wire non_empty = count != '0;
  wire full      = count == CNT_W'(DEPTH);
  wire pop       = !fifo_clr && data_rd && non_empty;
  wire push      = !fifo_clr && char_vld && (!full || pop);
  wire lost      = !fifo_clr && char_vld && full && !pop;
  wire [2:0] head_e = emem[rd_ptr];
  wire err_dec   = non_empty && (head_e != 3'b0) && !tag_seen && (tag_rd || pop);
  wire fifo_err  = (err_cnt != '0) || ovr_pend;
  wire rx_ev     = push && (cnt_nxt >= rx_lvl);
  wire tout_ev   = tout_en && !char_vld && (tcnt == TC_W'(TOUT_LIM - 1));

  assign rx_lvl  = CNT_W'((int'(trig_sel) + 1) * (DEPTH / 4));
  assign cnt_nxt = count + CNT_W'(push) - CNT_W'(pop);
  assign rd_data = non_empty ? dmem[rd_ptr] : '0;
  assign rd_tag  = non_empty ? {head_e, ovr_pend} : 4'b0;

  always_comb begin
    fifo_stat = '0;
    fifo_stat[PTR_W-1:0] = count[PTR_W-1:0];
    fifo_stat[8]  = full;
    fifo_stat[10] = fifo_err;
  end

  always_ff @(posedge clk) begin
    if (push) begin
      dmem[wr_ptr] <= char_data;
      emem[wr_ptr] <= char_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      err_cnt  <= '0;
      ovr_pend <= 1'b0;
      tag_seen <= 1'b0;
    end else if (fifo_clr) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      err_cnt  <= '0;
      ovr_pend <= 1'b0;
      tag_seen <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count   <= cnt_nxt;
      err_cnt <= err_cnt + CNT_W'(push && (char_err != 3'b0)) - CNT_W'(err_dec);
      if (lost)                      ovr_pend <= 1'b1;
      else if (tag_rd && non_empty)  ovr_pend <= 1'b0;
      if (pop)                       tag_seen <= 1'b0;
      else if (tag_rd && non_empty)  tag_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          tcnt <= '0;
    else if (char_vld || !tout_en)       tcnt <= '0;
    else if (tcnt != TC_W'(TOUT_LIM))    tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_flags <= 2'b0;
    else        irq_flags <= (irq_flags & ~irq_clr) | {tout_ev, rx_ev};
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R1
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_vld && full && !data_rd && !fifo_clr) |=> (count == CNT_W'(DEPTH)));

  // R2
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !non_empty && !char_vld && !fifo_clr) |=> (count == '0));

  // R4
  ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> rd_tag[0]);

  // R9
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (count == '0 && !fifo_stat[10]));

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ev || tout_ev) |=> (irq_flags != 2'b0));

endmodule

// File: tb/rx_err_fifo_tb.sv
`timescale 1ns/1ps
module rx_err_fifo_tb_top;
  localparam int LIM = 60;

  logic clk = 0, rst_n = 0;
  logic fifo_clr = 0, tout_en = 0, char_vld = 0, data_rd = 0, tag_rd = 0;
  logic [1:0] trig_sel = 0, irq_clr = 0;
  logic [7:0] char_data = 0;
  logic [2:0] char_err = 0;
  logic [7:0] rd_data;
  logic [3:0] rd_tag;
  logic [15:0] fifo_stat;
  logic [1:0] irq_flags;

  always #2.5 clk = ~clk;

  rx_err_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .trig_sel(trig_sel),
    .tout_en(tout_en), .char_vld(char_vld), .char_data(char_data),
    .char_err(char_err), .data_rd(data_rd), .tag_rd(tag_rd),
    .irq_clr(irq_clr), .rd_data(rd_data), .rd_tag(rd_tag),
    .fifo_stat(fifo_stat), .irq_flags(irq_flags));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] qd[$];
  logic [2:0] qe[$];
  bit m_ovr = 0, m_seen = 0;
  int m_ecnt = 0, m_tc = 0;
  logic [1:0] m_irq = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_stat();
    logic [15:0] s = '0;
    s[3:0] = 4'(qd.size());
    s[8]   = qd.size() == 16;
    s[10]  = (m_ecnt != 0) || m_ovr;
    return s;
  endfunction

  task automatic step(bit vld, logic [7:0] d, logic [2:0] e, bit drd, bit trd,
                      bit clr, logic [1:0] iclr);
    bit ne, pop, full, push, lost, dec, rxev, tev;
    @(negedge clk);
    char_vld = vld; char_data = d; char_err = e; data_rd = drd; tag_rd = trd;
    fifo_clr = clr; irq_clr = iclr;
    #1;
    ne = qd.size() > 0;
    // R2 R3 R4: head shown before it is consumed
    if (ne && drd) chk("R2 data order", rd_data, qd[0]);
    if (ne && trd) chk("R3 R4 tag", rd_tag, {qe[0], m_ovr});
    push = 0;
    if (clr) begin
      qd.delete(); qe.delete(); m_ovr = 0; m_seen = 0; m_ecnt = 0;
    end else begin
      pop  = drd && ne;
      full = qd.size() == 16;
      lost = vld && full && !pop;
      dec  = ne && (qe[0] != 0) && !m_seen && (trd || pop);
      if (lost) m_ovr = 1; else if (trd && ne) m_ovr = 0;
      if (pop) m_seen = 0; else if (trd && ne) m_seen = 1;
      if (pop) begin void'(qd.pop_front()); void'(qe.pop_front()); end
      push = vld && (!full || pop);
      if (push) begin qd.push_back(d); qe.push_back(e); end
      m_ecnt += ((push && e != 0) ? 1 : 0) - (dec ? 1 : 0);
    end
    rxev = push && (qd.size() >= 4 * (int'(trig_sel) + 1));
    tev = 0;
    if (vld || !tout_en) m_tc = 0;
    else if (m_tc != LIM) begin
      if (m_tc == LIM - 1) tev = 1;
      m_tc++;
    end
    m_irq = (m_irq & ~iclr) | {tev, rxev};
    @(posedge clk); #1;
    chk("R1 R5 R9 status", fifo_stat, exp_stat());
    chk("R6 R7 R8 irq", irq_flags, m_irq);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 stat", fifo_stat, 16'h0);
    chk("R10 irq", irq_flags, 2'b0);
    chk("R10 data", rd_data, 8'h0);
    chk("R10 tag", rd_tag, 4'h0);
    rst_n = 1;

    // R1 R6: fill to 16 at level 16, then overflow
    trig_sel = 2'd3;
    for (int i = 0; i < 16; i++) step(1, 8'(8'h30 + i), 3'(i % 3 == 0 ? 0 : i), 0, 0, 0, 0);
    chk("R1 full with count 0", {fifo_stat[8], fifo_stat[3:0]}, 5'h10);
    chk("R6 level 16", irq_flags[0], 1'b1);
    step(1, 8'hEE, 3'b000, 0, 0, 0, 0);  // R4 dropped
    chk("R1 drop keeps full", fifo_stat[8], 1'b1);
    // R4 overrun on first tag read, R5 drains by tag read and pop
    for (int i = 0; i < 16; i++) begin
      if (i < 10) step(0, 0, 0, 0, 1, 0, 0);
      step(0, 0, 0, 1, 0, 0, 0);
    end
    chk("R5 err flag clear when empty", fifo_stat[10], 1'b0);
    step(0, 0, 0, 1, 0, 0, 2'b11);  // R2 read on empty
    chk("R8 cleared", irq_flags, 2'b00);

    // R7 timeout on empty queue, then W1C with colliding event R8
    tout_en = 1;
    idle(LIM);
    chk("R7 empty timeout", irq_flags[1], 1'b1);
    step(1, 8'h55, 3'b100, 0, 0, 0, 0);
    idle(LIM - 2);
    step(0, 0, 0, 0, 0, 0, 2'b10);
    chk("R8 clear", irq_flags[1], 1'b0);
    step(0, 0, 0, 0, 0, 0, 2'b10);
    chk("R8 event beats clear", irq_flags[1], 1'b1);

    // R9 flush with a character in the same cycle
    step(1, 8'h11, 3'b001, 0, 0, 1, 0);
    chk("R9 flushed", fifo_stat, 16'h0);

    // random mix
    void'($urandom(32'd1357));
    for (int i = 0; i < 6000; i++) begin
      if (i % 500 == 0) begin
        trig_sel = 2'($urandom_range(0, 3));
        tout_en  = ($urandom_range(0, 3) != 0);
      end
      if ((i / 700) % 3 == 2)
        step($urandom_range(0, 40) == 0, 8'($urandom), 3'($urandom),
             $urandom_range(0, 3) == 0, $urandom_range(0, 1),
             0, 2'($urandom_range(0, 3) == 0 ? $urandom : 0));
      else
        step($urandom_range(0, 1), 8'($urandom),
             ($urandom_range(0, 2) == 0) ? 3'($urandom) : 3'b0,
             $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0,
             $urandom_range(0, 150) == 0, 2'($urandom_range(0, 7) == 0 ? $urandom : 0));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule